// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is a bus master that runs back-to-back conversions on 12-bit serial analog-to-digital converters. The converters share a serial clock and a single bidirectional data line, and each has its own active-low chip select. In every frame the master selects one converter and shifts a 5-bit configuration word out to it on the data line. It then stops driving the line so the converter can answer, and it shifts in a leading null bit followed by the 12 result bits, most significant first. When the final bit has been sampled, the master deselects the converter, reports the result with a one-cycle strobe, and starts the next frame on its own.

The serial clock is made from the system clock by a half-period divider. Every high phase and every low phase of the serial clock lasts `HALF_DIV` system clocks, and `HALF_DIV` is clamped to at least 2. Each configuration bit goes onto the line at the start of a low phase. It therefore has at least one system clock of setup before the rising edge on which the converter captures it. Each result bit is sampled on the last system clock of a low phase, just before the next rising edge.

The frame walks through these states: GAP (all chip selects high, clock low), SEL (chip select low, clock low), CFG_LO and CFG_HI (one pair per configuration bit), then RD_LO and RD_HI (one pair per read bit). The transitions are:
- GAP to SEL: the device index is latched.
- SEL to CFG_LO.
- CFG_LO to CFG_HI.
- CFG_HI back to CFG_LO, or to RD_LO after the fifth bit. This is the turnaround.
- RD_LO to RD_HI.
- RD_HI back to RD_LO.
- RD_LO to GAP after the thirteenth sample. The result is posted on this transition.

Top module: `adc_conv_master`

## Requirements
- R1: While reset is asserted, every `cs_n` bit is 1, and `sclk`, `sd_oe` and `res_valid` are 0.
- R2: During a frame, exactly one `cs_n` bit is low: bit `i`, where `i` is the `dev_sel` value latched when the frame began. The pattern does not change until the frame ends.
- R3: Each frame sends `CFG_WORD` (default 5'b10011) most significant bit first. There is one bit per rising `sclk` edge. `sd_oe` is high and `sd_out` is already stable on the system clock before each of these five rising edges.
- R4: Once the fifth configuration rising edge has passed, `sd_oe` stays low for the rest of the frame. Each frame has exactly 17 rising `sclk` edges: 5 for configuration and 12 for reading.
- R5: The 13 bits sampled from `sd_in` (one per read low phase) are the null bit followed by B11 down to B0. `res_data` equals B11..B0, with B11 at bit 11.
- R6: `res_valid` is high for exactly one system clock per frame. `res_dev` equals the index that was selected for that frame.
- R7: `frame_err` is valid together with `res_valid`. It is 1 if the sampled null bit was 1, and 0 if the null bit was 0.
- R8: `cs_n` returns to all ones right after the final sample, with `sclk` low and `sd_oe` low. All ones lasts exactly `HALF_DIV` system clocks, and then the next frame begins without any input action.
- R9: Every `sclk` high phase, and every low phase between two rising edges of a frame, lasts exactly `HALF_DIV` system clocks.
- R10: Changing `dev_sel` in the middle of a frame does not affect that frame. The new value takes effect at the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel | input | DEV_W | Index of the converter to address in the next frame |
| sclk | output | 1 | Serial clock to all converters |
| cs_n | output | NUM_DEV | Active-low chip select, one per converter |
| sd_out | output | 1 | Value driven onto the shared data line |
| sd_oe | output | 1 | Drive enable for the data line (0 means released) |
| sd_in | input | 1 | Level read from the shared data line |
| res_valid | output | 1 | One-cycle strobe marking a finished conversion |
| res_data | output | RES_W | Conversion result, B11..B0 |
| res_dev | output | DEV_W | Converter index that produced `res_data` |
| frame_err | output | 1 | Set when the null bit of the frame was not zero |

## Verification
The bench goes after three corner cases. The first is the turnaround: a master that releases the line one phase late would still be driving while the converter answers. The second is the last bit, which is sampled on the same edge that ends the frame. A design that posts the shift register's old contents there would lose B0, and the all-zero and all-one patterns, together with alternating patterns, expose that error. The third is a device-select change in the middle of a frame. A master that decodes chip select straight from `dev_sel` would switch converters partway through and report the wrong index. The bench also forces a null bit of 1 to confirm the error flag, and it measures the deselect gap so that an early or late restart is caught.

// File: rtl/adc_master_pkg.sv
package adc_master_pkg;

    localparam int ADC_CFG_BITS = 5;
    localparam int ADC_RES_BITS = 12;

    typedef enum logic [2:0] {
        ST_GAP,
        ST_SEL,
        ST_CFG_LO,
        ST_CFG_HI,
        ST_RD_LO,
        ST_RD_HI
    } adc_state_e;

endpackage

// File: rtl/adc_phase_timer.sv
module adc_phase_timer #(
    parameter int HALF_DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int EFF_DIV = (HALF_DIV < 2) ? 2 : HALF_DIV;
    localparam int TW      = $clog2(EFF_DIV);

    logic [TW-1:0] cnt_q;

    assign tick = (cnt_q == TW'(EFF_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (clear) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[W-2:0], din};
        end
    end
endmodule

// File: rtl/adc_cs_decode.sv
module adc_cs_decode #(
    parameter int NUM_DEV = 2,
    parameter int DEV_W   = 1
) (
    input  logic               active,
    input  logic [DEV_W-1:0]   dev,
    output logic [NUM_DEV-1:0] cs_n
);
    for (genvar i = 0; i < NUM_DEV; i++) begin : g_sel
        assign cs_n[i] = !(active && (dev == DEV_W'(i)));
    end
endmodule

// File: rtl/adc_conv_master.sv
module adc_conv_master
    import adc_master_pkg::*;
#(
    parameter int                NUM_DEV  = 2,
    parameter int                HALF_DIV = 100,
    parameter int                CFG_W    = ADC_CFG_BITS,
    parameter logic [CFG_W-1:0]  CFG_WORD = 5'b10011,
    parameter int                RES_W    = ADC_RES_BITS,
    localparam int               DEV_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DEV_W-1:0]   dev_sel,
    output logic               sclk,
    output logic [NUM_DEV-1:0] cs_n,
    output logic               sd_out,
    output logic               sd_oe,
    input  logic               sd_in,
    output logic               res_valid,
    output logic [RES_W-1:0]   res_data,
    output logic [DEV_W-1:0]   res_dev,
    output logic               frame_err
);
    localparam int RX_W  = RES_W + 1;
    localparam int MAXB  = (RX_W > CFG_W) ? RX_W : CFG_W;
    localparam int CNT_W = $clog2(MAXB + 1);

    adc_state_e        state_q, state_d;
    logic              tick;
    logic [CNT_W-1:0]  bit_q;
    logic [CFG_W-1:0]  cfg_sr_q;
    logic [DEV_W-1:0]  cur_dev_q;
    logic [RX_W-1:0]   rx_word;
    logic [RX_W-1:0]   final_word;
    logic              cfg_last, rd_last, frame_active;

    assign cfg_last = (bit_q == CNT_W'(CFG_W - 1));
    assign rd_last  = (bit_q == CNT_W'(RX_W - 1));

    adc_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    adc_rx_shift #(.W(RX_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (tick && (state_q == ST_GAP)),
        .shift_en (tick && (state_q == ST_RD_LO)),
        .din      (sd_in),
        .word     (rx_word)
    );

    adc_cs_decode #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_cs (
        .active (frame_active),
        .dev    (cur_dev_q),
        .cs_n   (cs_n)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                ST_GAP:    state_d = ST_SEL;
                ST_SEL:    state_d = ST_CFG_LO;
                ST_CFG_LO: state_d = ST_CFG_HI;
                ST_CFG_HI: state_d = cfg_last ? ST_RD_LO : ST_CFG_LO;
                ST_RD_LO:  state_d = rd_last ? ST_GAP : ST_RD_HI;
                ST_RD_HI:  state_d = ST_RD_LO;
                default:   state_d = ST_GAP;
            endcase
        end
    end

    // state register and frame counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_GAP;
            bit_q     <= '0;
            cfg_sr_q  <= '0;
            cur_dev_q <= '0;
        end else begin
            state_q <= state_d;
            if (tick) begin
                unique case (state_q)
                    ST_GAP: begin
                        cur_dev_q <= dev_sel;
                        bit_q     <= '0;
                    end
                    ST_SEL: begin
                        cfg_sr_q <= CFG_WORD;
                        bit_q    <= '0;
                    end
                    ST_CFG_HI: begin
                        cfg_sr_q <= {cfg_sr_q[CFG_W-2:0], 1'b0};
                        bit_q    <= cfg_last ? '0 : bit_q + 1'b1;
                    end
                    ST_RD_LO: begin
                        bit_q <= rd_last ? '0 : bit_q + 1'b1;
                    end
                    default: begin
                        bit_q <= bit_q;
                    end
                endcase
            end
        end
    end

    // pin outputs decoded from state
    assign frame_active = (state_q != ST_GAP);
    assign sclk         = (state_q == ST_CFG_HI) || (state_q == ST_RD_HI);
    assign sd_oe        = (state_q == ST_CFG_LO) || (state_q == ST_CFG_HI);
    assign sd_out       = sd_oe && cfg_sr_q[CFG_W-1];

    // result outputs: the final bit joins the word on the closing edge
    assign final_word = {rx_word[RX_W-2:0], sd_in};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_dev   <= '0;
            frame_err <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (tick && (state_q == ST_RD_LO) && rd_last) begin
                res_valid <= 1'b1;
                res_data  <= final_word[RES_W-1:0];
                frame_err <= final_word[RX_W-1];
                res_dev   <= cur_dev_q;
            end
        end
    end
endmodule

// File: rtl/adc_conv_master_chk.sv
module adc_conv_master_chk #(
    parameter int NUM_DEV  = 2,
    parameter int HALF_DIV = 100
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sclk,
    input logic [NUM_DEV-1:0] cs_n,
    input logic               sd_oe,
    input logic               sd_out,
    input logic               res_valid
);
    localparam int EFF_DIV = (HALF_DIV < 2) ? 2 : HALF_DIV;
    localparam int LW      = $clog2(EFF_DIV + 2) + 1;

    logic [LW-1:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len <= '0;
        end else if (sclk) begin
            hi_len <= hi_len + 1'b1;
        end else begin
            hi_len <= '0;
        end
    end

    AST_CS_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n)); // R2
    AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && $past(!(&cs_n))) |-> $stable(cs_n)); // R10
    AST_CFG_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_oe && $rose(sclk)) |-> ($past(sd_oe) && $stable(sd_out))); // R3
    AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sd_oe |-> !(&cs_n)); // R4
    AST_RELEASE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sd_oe) |-> (!sclk && !(&cs_n))); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((&cs_n) && !sclk && !sd_oe)); // R8
    AST_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> (hi_len == LW'(EFF_DIV))); // R9
endmodule

bind adc_conv_master adc_conv_master_chk #(
    .NUM_DEV  (NUM_DEV),
    .HALF_DIV (HALF_DIV)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .sd_oe     (sd_oe),
    .sd_out    (sd_out),
    .res_valid (res_valid)
);

// File: tb/tb_adc_conv_master.sv
`timescale 1ns/1ps
module tb_adc_conv_master;
    localparam int NDEV = 3;
    localparam int HALF = 3;
    localparam int DW   = 2;
    localparam logic [4:0] CFG = 5'b10011;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [DW-1:0]   dev_sel = '0;
    logic            sclk, sd_out, sd_oe, res_valid, frame_err;
    logic [NDEV-1:0] cs_n;
    logic [11:0]     res_data;
    logic [DW-1:0]   res_dev;
    logic            line_bit = 1'b1;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #2.5 clk = ~clk;

    adc_conv_master #(
        .NUM_DEV(NDEV), .HALF_DIV(HALF), .CFG_W(5), .CFG_WORD(CFG), .RES_W(12)
    ) dut (
        .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .sclk(sclk), .cs_n(cs_n),
        .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(line_bit), .res_valid(res_valid),
        .res_data(res_data), .res_dev(res_dev), .frame_err(frame_err)
    );

    // converter models and line monitor
    logic [11:0]     dev_val [NDEV];
    logic            dev_null[NDEV];
    int              rise_cnt = 0, hi_run = 0, lo_run = 0, gap_cnt = 0, last_gap = 0;
    logic [4:0]      cfg_cap = '0;
    bit              late = 0, setup_bad = 0, phase_bad = 0, cs_bad = 0;
    logic [NDEV-1:0] frame_csn = '1;
    logic            sclk_q = 0, oe_q = 0, out_q = 0, idle_q = 1;
    int              snap_rise = 0;
    logic [4:0]      snap_cfg = '0;
    bit              snap_late = 0, snap_setup = 0, snap_phase = 0, snap_csbad = 0;
    logic [NDEV-1:0] snap_csn = '1;

    always @(negedge clk) begin
        logic idle;
        idle = &cs_n;
        if (!idle && idle_q) begin
            rise_cnt = 0; cfg_cap = '0; late = 0; setup_bad = 0;
            phase_bad = 0; cs_bad = 0; frame_csn = cs_n; last_gap = gap_cnt;
        end
        if (idle && !idle_q) begin
            snap_rise = rise_cnt; snap_cfg = cfg_cap; snap_late = late;
            snap_setup = setup_bad; snap_phase = phase_bad;
            snap_csn = frame_csn; snap_csbad = cs_bad;
        end
        gap_cnt = idle ? gap_cnt + 1 : 0;
        if (!idle) begin
            if (cs_n != frame_csn) cs_bad = 1;
            if (sclk && !sclk_q) begin
                rise_cnt++;
                if (rise_cnt > 1 && lo_run != HALF) phase_bad = 1;
                if (rise_cnt <= 5) begin
                    if (!(oe_q && sd_oe && out_q == sd_out)) setup_bad = 1;
                    cfg_cap = {cfg_cap[3:0], sd_out};
                end
            end
            if (!sclk && sclk_q) begin
                if (hi_run != HALF) phase_bad = 1;
                if (rise_cnt >= 5 && rise_cnt <= 17) begin
                    for (int d = 0; d < NDEV; d++) begin
                        if (!cs_n[d]) line_bit = ({dev_null[d], dev_val[d]} >> (17 - rise_cnt)) & 13'd1;
                    end
                end
            end
            if (rise_cnt >= 5 && sd_oe && !sclk) late = 1;
        end else begin
            line_bit = 1'b1;
        end
        if (sclk) hi_run = sclk_q ? hi_run + 1 : 1;
        else      lo_run = !sclk_q ? lo_run + 1 : 1;
        sclk_q = sclk; oe_q = sd_oe; out_q = sd_out; idle_q = idle;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!res_valid) @(negedge clk);
        #0.1;
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk(&cs_n, "R1 cs_n", cs_n, {NDEV{1'b1}});
        chk(!sclk && !sd_oe && !res_valid, "R1 sclk/oe/valid", {sclk, sd_oe, res_valid}, 0);
        rst_n = 1'b1;
        wait_done();
    endtask

    task automatic t_frame(input int d, input logic [11:0] v);
        dev_sel = DW'(d); dev_val[d] = v; dev_null[d] = 1'b0;
        wait_done();  // frame carrying the new setting
        chk(res_data == v, "R5 data", res_data, v);
        chk(res_dev == DW'(d), "R6 dev", res_dev, d);
        chk(frame_err == 1'b0, "R7 clean null", frame_err, 0);
        chk(snap_csn == ~(NDEV'(1) << d) && !snap_csbad, "R2 cs pattern", snap_csn, ~(NDEV'(1) << d));
        chk(snap_cfg == CFG && !snap_setup, "R3 cfg word", snap_cfg, CFG);
        chk(snap_rise == 17 && !snap_late, "R4 edges/release", snap_rise, 17);
        chk(!snap_phase, "R9 phase widths", snap_phase, 0);
        @(negedge clk); #0.1;
        chk(!res_valid, "R6 pulse width", res_valid, 0);
    endtask

    task automatic t_null_err();
        dev_sel = 2'd1; dev_val[1] = 12'h3C5; dev_null[1] = 1'b1;
        wait_done();
        chk(frame_err == 1'b1, "R7 null set", frame_err, 1);
        chk(res_data == 12'h3C5, "R7 data kept", res_data, 12'h3C5);
        dev_null[1] = 1'b0;
        wait_done();
        chk(frame_err == 1'b0, "R7 null cleared", frame_err, 0);
    endtask

    task automatic t_gap();
        wait_done();
        chk(&cs_n && !sclk && !sd_oe, "R8 idle after done", cs_n, {NDEV{1'b1}});
        @(negedge clk);
        while (&cs_n) @(negedge clk);
        #0.1;
        chk(last_gap == HALF, "R8 gap length", last_gap, HALF);
    endtask

    task automatic t_dev_switch();
        dev_sel = 2'd0; dev_val[0] = 12'h111; dev_val[2] = 12'h222;
        wait_done();
        @(negedge clk);
        while (&cs_n) @(negedge clk);
        dev_sel = 2'd2;  // mid-frame change
        wait_done();
        chk(res_dev == 2'd0 && res_data == 12'h111, "R10 current frame", res_dev, 0);
        chk(!snap_csbad && snap_csn == 3'b110, "R10 cs held", snap_csn, 3'b110);
        wait_done();
        chk(res_dev == 2'd2 && res_data == 12'h222, "R10 next frame", res_dev, 2);
    endtask

    initial begin
        for (int d = 0; d < NDEV; d++) begin
            dev_val[d] = '0; dev_null[d] = 1'b0;
        end
        t_reset();
        t_frame(0, 12'hABC);
        t_frame(1, 12'h000);
        t_frame(2, 12'hFFF);
        t_frame(0, 12'h555);
        t_frame(1, 12'hAAA);
        t_frame(2, 12'h801);
        t_null_err();
        t_gap();
        t_dev_switch();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end
endmodule